// File: doc/BRIEF.md
# Linear Charger Control Sequencer

This block is the digital sequencer of a single-cell lithium-ion charger. The analog current and voltage loops sit outside it. It sees them only as comparator and loop-status flags, and it tells them which current to regulate to. From reset or disable it first checks that a battery is present. It then walks through conditioning pre-charge, constant-current fast charge and constant-voltage taper, and it stops once the taper current drops below the termination level.

After termination the sequencer keeps watching the battery. When the battery sags below the recharge level, it confirms again that the battery is present and then tops it up. Two safety timers, one for pre-charge and one for the fast and taper phases, are advanced by a slow tick. Any active current-reduction loop slows them by a programmable fraction. Each phase has its own current-select code, a drive level for an open-drain status output, and a thermistor-sense enable. A fault flag stays set until the block is disabled or loses input power.

Top module: `chg_seq_top`

## Requirements
- R1: While rst_ni is low, or in the cycle after en_i or vin_good_i is low, phase_o is 0 (idle), isel_o is 0, stat_on_o, ts_en_o and fault_o are 0, and both safety timers are cleared.
- R2: From idle with en_i and vin_good_i high, phase_o goes to 1 (detect) for one cycle. From detect it goes to 8 (fault) if bat_short_ok_i is low, to 3 (fast) if bat_lowv_i is high, and otherwise to 2 (pre-charge).
- R3: In pre-charge isel_o is 1 (one tenth of the fast current). The block moves to fast charge when bat_lowv_i is high.
- R4: In fast charge isel_o is 2. The block moves to 4 (constant voltage) when bat_reg_i is high, and isel_o stays 2 in constant voltage.
- R5: Constant voltage ends in 5 (done, isel_o 0) when term_i is high, but only while red_thermal_i, red_dppm_i and red_vinlow_i are all low.
- R6: In done, bat_rch_i high moves to 6 (presence re-check). From there the block goes to 7 (recharge, isel_o 2, status released) if bat_short_ok_i is high, and to fault if it is low. Recharge returns to done when bat_reg_i is high.
- R7: After PRE_LIMIT counted ticks in pre-charge without reaching the low-voltage level, the block enters fault. fault_o goes to 1 and isel_o to 0.
- R8: After FAST_LIMIT counted ticks spent in fast charge and constant voltage together, or in recharge, the block enters fault.
- R9: While any reduction flag is high, a timer advances on only one of every red_scale_i+1 ticks.
- R10: stat_on_o is 1 only in pre-charge, fast and constant voltage, and it is 0 in the cycle after vin_ovp_i is high.
- R11: In a charging phase, vin_ovp_i high or (ts_present_i high and ts_ok_i low) sets isel_o to 0 and freezes both the phase and the timers.
- R12: ts_en_o is 1 exactly when the phase is a charging phase (2, 3, 4 or 7) and ts_present_i is high.
- R13: Fault persists whatever the battery flags do. Only en_i low or vin_good_i low clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Charger enable |
| tick_i | input | 1 | One-cycle pulse at 1 Hz for the safety timers |
| vin_good_i | input | 1 | Input supply present and above lockout |
| vin_ovp_i | input | 1 | Input supply over-voltage |
| bat_short_ok_i | input | 1 | Battery above short-detect level |
| bat_lowv_i | input | 1 | Battery above pre-charge/fast-charge threshold |
| bat_reg_i | input | 1 | Battery at regulation voltage |
| bat_rch_i | input | 1 | Battery below recharge level |
| term_i | input | 1 | Charge current below termination level |
| ts_present_i | input | 1 | Thermistor detected |
| ts_ok_i | input | 1 | Thermistor temperature inside charge window |
| red_thermal_i | input | 1 | Thermal reduction loop active |
| red_dppm_i | input | 1 | Load-sharing reduction loop active |
| red_vinlow_i | input | 1 | Input-low reduction loop active |
| red_scale_i | input | SCALE_W | Timer slowdown code while reducing |
| phase_o | output | 4 | Charge phase code |
| isel_o | output | 2 | Current select: 0 off, 1 pre-charge, 2 fast |
| stat_on_o | output | 1 | Status sink enable (1 = sinking) |
| ts_en_o | output | 1 | Temperature sense enable |
| fault_o | output | 1 | Fault flag |

## Verification
One full charge cycle runs through the main path: detection, pre-charge, fast charge, taper, termination, sag, re-check and recharge. That run separates the phase order and the current code of each phase. A termination attempt under an active thermal loop, held against the one without it, shows whether the reduction loops really block termination. The timer runs use plain ticks, then ticks under reduction with a halving code, and an expiry spread across fast charge and taper. Together they tell apart counting per tick, the slowed counting, and a timer that wrongly restarts on entering constant voltage. The remaining directed cases cover a failed detection, a missing battery at re-check, over-voltage and temperature pauses, and the ways fault is cleared.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;
  typedef enum logic [3:0] {
    PH_IDLE   = 4'd0,
    PH_DETECT = 4'd1,
    PH_PRE    = 4'd2,
    PH_FAST   = 4'd3,
    PH_CV     = 4'd4,
    PH_DONE   = 4'd5,
    PH_RCHK   = 4'd6,
    PH_RECH   = 4'd7,
    PH_FAULT  = 4'd8
  } phase_e;

  localparam logic [1:0] ISEL_OFF  = 2'd0;
  localparam logic [1:0] ISEL_PRE  = 2'd1;
  localparam logic [1:0] ISEL_FAST = 2'd2;

  function automatic logic is_timed(phase_e p);
    return (p == PH_PRE) || (p == PH_FAST) || (p == PH_CV) || (p == PH_RECH);
  endfunction
endpackage

// File: rtl/chg_tick_div.sv
module chg_tick_div #(
  parameter int SCALE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               red_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               adv_o
);
  logic [SCALE_W-1:0] div_q;
  logic hit;

  assign hit   = (div_q >= scale_i);
  assign adv_o = tick_i & run_i & (~red_i | hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             div_q <= '0;
    else if (!red_i)         div_q <= '0;
    else if (tick_i && run_i) div_q <= hit ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
  parameter int PRE_LIMIT  = 1800,
  parameter int FAST_LIMIT = 18000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  input  logic pre_sel_i,
  output logic expired_o
);
  localparam int MAX_L = (PRE_LIMIT > FAST_LIMIT) ? PRE_LIMIT : FAST_LIMIT;
  localparam int CW    = $clog2(MAX_L + 1);
  localparam logic [CW-1:0] PRE_V  = CW'(PRE_LIMIT);
  localparam logic [CW-1:0] FAST_V = CW'(FAST_LIMIT);
  localparam logic [CW-1:0] MAX_V  = CW'(MAX_L);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (adv_i && cnt_q < MAX_V) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = pre_sel_i ? (cnt_q >= PRE_V) : (cnt_q >= FAST_V);
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       vin_good_i,
  input  logic       vin_ovp_i,
  input  logic       bat_short_ok_i,
  input  logic       bat_lowv_i,
  input  logic       bat_reg_i,
  input  logic       bat_rch_i,
  input  logic       term_i,
  input  logic       ts_present_i,
  input  logic       ts_ok_i,
  input  logic       any_red_i,
  input  logic       expired_i,
  output logic       timer_clr_o,
  output logic       timer_run_o,
  output logic       pre_sel_o,
  output logic [3:0] phase_o,
  output logic [1:0] isel_o,
  output logic       stat_on_o,
  output logic       ts_en_o,
  output logic       fault_o
);
  phase_e st_q, st_d;
  logic pause, timed_d;
  logic [1:0] isel_d;

  assign pause = vin_ovp_i | (ts_present_i & ~ts_ok_i);

  always_comb begin
    st_d = st_q;
    if (!en_i || !vin_good_i) begin
      st_d = PH_IDLE;
    end else begin
      unique case (st_q)
        PH_IDLE:   st_d = PH_DETECT;
        PH_DETECT: begin
          if (!bat_short_ok_i) st_d = PH_FAULT;
          else if (bat_lowv_i) st_d = PH_FAST;
          else                 st_d = PH_PRE;
        end
        PH_PRE: if (!pause) begin
          if (bat_lowv_i)     st_d = PH_FAST;
          else if (expired_i) st_d = PH_FAULT;
        end
        PH_FAST: if (!pause) begin
          if (expired_i)      st_d = PH_FAULT;
          else if (bat_reg_i) st_d = PH_CV;
        end
        PH_CV: if (!pause) begin
          if (expired_i)                 st_d = PH_FAULT;
          else if (term_i && !any_red_i) st_d = PH_DONE;
        end
        PH_DONE:  if (bat_rch_i) st_d = PH_RCHK;
        PH_RCHK:  st_d = bat_short_ok_i ? PH_RECH : PH_FAULT;
        PH_RECH: if (!pause) begin
          if (expired_i)      st_d = PH_FAULT;
          else if (bat_reg_i) st_d = PH_DONE;
        end
        PH_FAULT: st_d = PH_FAULT;
        default:  st_d = PH_IDLE;
      endcase
    end
  end

  assign timed_d = is_timed(st_d);
  assign isel_d  = (!timed_d || pause) ? ISEL_OFF :
                   (st_d == PH_PRE)    ? ISEL_PRE : ISEL_FAST;

  // timer restarts only when entering a phase that owns a fresh budget
  assign timer_clr_o = (st_q == PH_IDLE) ||
                       ((st_d != st_q) &&
                        ((st_d == PH_PRE) || (st_d == PH_FAST) || (st_d == PH_RECH)));
  assign timer_run_o = is_timed(st_q) && !pause;
  assign pre_sel_o   = (st_q == PH_PRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= PH_IDLE;
      isel_o    <= ISEL_OFF;
      stat_on_o <= 1'b0;
      ts_en_o   <= 1'b0;
      fault_o   <= 1'b0;
    end else begin
      st_q      <= st_d;
      isel_o    <= isel_d;
      stat_on_o <= ((st_d == PH_PRE) || (st_d == PH_FAST) || (st_d == PH_CV)) && !vin_ovp_i;
      ts_en_o   <= timed_d && ts_present_i;
      fault_o   <= (st_d == PH_FAULT);
    end
  end

  assign phase_o = st_q;
endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top #(
  parameter int PRE_LIMIT  = 1800,
  parameter int FAST_LIMIT = 18000,
  parameter int SCALE_W    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               vin_good_i,
  input  logic               vin_ovp_i,
  input  logic               bat_short_ok_i,
  input  logic               bat_lowv_i,
  input  logic               bat_reg_i,
  input  logic               bat_rch_i,
  input  logic               term_i,
  input  logic               ts_present_i,
  input  logic               ts_ok_i,
  input  logic               red_thermal_i,
  input  logic               red_dppm_i,
  input  logic               red_vinlow_i,
  input  logic [SCALE_W-1:0] red_scale_i,
  output logic [3:0]         phase_o,
  output logic [1:0]         isel_o,
  output logic               stat_on_o,
  output logic               ts_en_o,
  output logic               fault_o
);
  logic any_red, expired, timer_clr, timer_run, pre_sel, adv;

  assign any_red = red_thermal_i | red_dppm_i | red_vinlow_i;

  chg_tick_div #(.SCALE_W(SCALE_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .run_i   (timer_run),
    .red_i   (any_red),
    .scale_i (red_scale_i),
    .adv_o   (adv)
  );

  chg_safety_timer #(.PRE_LIMIT(PRE_LIMIT), .FAST_LIMIT(FAST_LIMIT)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (timer_clr),
    .adv_i     (adv),
    .pre_sel_i (pre_sel),
    .expired_o (expired)
  );

  chg_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (en_i),
    .vin_good_i     (vin_good_i),
    .vin_ovp_i      (vin_ovp_i),
    .bat_short_ok_i (bat_short_ok_i),
    .bat_lowv_i     (bat_lowv_i),
    .bat_reg_i      (bat_reg_i),
    .bat_rch_i      (bat_rch_i),
    .term_i         (term_i),
    .ts_present_i   (ts_present_i),
    .ts_ok_i        (ts_ok_i),
    .any_red_i      (any_red),
    .expired_i      (expired),
    .timer_clr_o    (timer_clr),
    .timer_run_o    (timer_run),
    .pre_sel_o      (pre_sel),
    .phase_o        (phase_o),
    .isel_o         (isel_o),
    .stat_on_o      (stat_on_o),
    .ts_en_o        (ts_en_o),
    .fault_o        (fault_o)
  );
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       vin_good_i,
  input logic       vin_ovp_i,
  input logic       red_thermal_i,
  input logic       red_dppm_i,
  input logic       red_vinlow_i,
  input logic [3:0] phase_o,
  input logic [1:0] isel_o,
  input logic       stat_on_o,
  input logic       ts_en_o,
  input logic       fault_o
);
  logic any_red;
  assign any_red = red_thermal_i | red_dppm_i | red_vinlow_i;

  AST_DISABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase_o == 4'd0 && isel_o == 2'd0 && !stat_on_o && !fault_o && !ts_en_o)); // R1

  AST_PRE_CURRENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 4'd2) |-> (isel_o != 2'd2)); // R3

  AST_NO_TERM_UNDER_RED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 4'd4 && any_red) |=> (phase_o != 4'd5)); // R5

  AST_DONE_NO_CURRENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 4'd5) |-> (isel_o == 2'd0 && !stat_on_o)); // R6

  AST_STAT_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_on_o |-> (phase_o == 4'd2 || phase_o == 4'd3 || phase_o == 4'd4)); // R10

  AST_OVP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vin_ovp_i |=> !stat_on_o); // R10

  AST_TS_EN_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_en_o |-> (phase_o == 4'd2 || phase_o == 4'd3 || phase_o == 4'd4 || phase_o == 4'd7)); // R12

  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && en_i && vin_good_i) |=> fault_o); // R13

  AST_FAULT_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (isel_o == 2'd0 && !stat_on_o && phase_o == 4'd8)); // R7
endmodule

bind chg_seq_top chg_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .vin_good_i    (vin_good_i),
  .vin_ovp_i     (vin_ovp_i),
  .red_thermal_i (red_thermal_i),
  .red_dppm_i    (red_dppm_i),
  .red_vinlow_i  (red_vinlow_i),
  .phase_o       (phase_o),
  .isel_o        (isel_o),
  .stat_on_o     (stat_on_o),
  .ts_en_o       (ts_en_o),
  .fault_o       (fault_o)
);

// File: tb/chg_seq_top_bench.sv
module chg_seq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P_PRE  = 6;
  localparam int P_FAST = 10;
  localparam int N_VEC  = 11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en, tick, vin, ovp, shrt, lowv, regv, rch, term, tsp, tsok, red_th;
  logic [1:0] scale;
  logic [3:0] phase;
  logic [1:0] isel;
  logic stat_on, ts_en, fault;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_seq_top #(.PRE_LIMIT(P_PRE), .FAST_LIMIT(P_FAST), .SCALE_W(2)) u_chg_seq_top (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .tick_i(tick), .vin_good_i(vin),
    .vin_ovp_i(ovp), .bat_short_ok_i(shrt), .bat_lowv_i(lowv), .bat_reg_i(regv),
    .bat_rch_i(rch), .term_i(term), .ts_present_i(tsp), .ts_ok_i(tsok),
    .red_thermal_i(red_th), .red_dppm_i(1'b0), .red_vinlow_i(1'b0),
    .red_scale_i(scale), .phase_o(phase), .isel_o(isel), .stat_on_o(stat_on),
    .ts_en_o(ts_en), .fault_o(fault)
  );

  // flags {en,vin,short,lowv,reg,rch,term,tsp,tsok,red,ovp}, phase, isel, stat
  localparam logic [17:0] VEC [N_VEC] = '{
    {11'b11100000100, 4'd1, 2'd0, 1'b0},  // R2 detect
    {11'b11100000100, 4'd2, 2'd1, 1'b1},  // R3 pre
    {11'b11100000100, 4'd2, 2'd1, 1'b1},
    {11'b11110000100, 4'd3, 2'd2, 1'b1},  // R3 -> fast
    {11'b11111000100, 4'd4, 2'd2, 1'b1},  // R4 cv
    {11'b11111010110, 4'd4, 2'd2, 1'b1},  // R5 blocked by thermal loop
    {11'b11111010100, 4'd5, 2'd0, 1'b0},  // R5 done
    {11'b11110000100, 4'd5, 2'd0, 1'b0},
    {11'b11110100100, 4'd6, 2'd0, 1'b0},  // R6 recheck
    {11'b11110100100, 4'd7, 2'd2, 1'b0},  // R6 recharge
    {11'b11111000100, 4'd5, 2'd0, 1'b0}   // R6 back to done
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_flags(input logic [10:0] f);
    {en, vin, shrt, lowv, regv, rch, term, tsp, tsok, red_th, ovp} = f;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    tick = 1'b1;
    cyc(n);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tick = 1'b0;
    scale = 2'd0;
    set_flags(11'b0);
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset phase", phase, 0);
    chk("R1 reset isel", isel, 0);
    chk("R1 reset stat", stat_on, 0);
    chk("R1 reset fault", fault, 0);

    // main charge cycle table
    for (int i = 0; i < N_VEC; i++) begin
      set_flags(VEC[i][17:7]);
      cyc(1);
      chk($sformatf("R4 vec%0d phase", i), phase, VEC[i][6:3]);
      chk($sformatf("R4 vec%0d isel", i), isel, VEC[i][2:1]);
      chk($sformatf("R10 vec%0d stat", i), stat_on, VEC[i][0]);
    end

    // R1 disable mid-charge
    do_reset();
    set_flags(11'b11100000100); cyc(2);
    set_flags(11'b01100000100); cyc(1);
    chk("R1 disable phase", phase, 0);
    chk("R1 disable stat", stat_on, 0);

    // R2 failed detection, R13 sticky fault
    do_reset();
    set_flags(11'b11000000100); cyc(1);
    chk("R2 detect", phase, 1);
    cyc(1);
    chk("R2 no battery fault", fault, 1);
    chk("R2 fault phase", phase, 8);
    set_flags(11'b11111000100); cyc(3);
    chk("R13 fault sticky", fault, 1);
    set_flags(11'b10111000100); cyc(1);
    chk("R13 vin loss clears", fault, 0);
    chk("R13 vin loss idle", phase, 0);

    // R7 pre-charge timer
    do_reset();
    set_flags(11'b11100000100); cyc(2);
    pulse(P_PRE - 1); cyc(1);
    chk("R7 pre before expiry", phase, 2);
    pulse(1); cyc(1);
    chk("R7 pre expiry fault", fault, 1);
    chk("R7 fault isel", isel, 0);

    // R9 slowed timer: code 1 halves the rate
    do_reset();
    scale = 2'd1;
    set_flags(11'b11100000110); cyc(2);
    pulse(2 * P_PRE - 1); cyc(1);
    chk("R9 slowed still pre", phase, 2);
    pulse(1); cyc(1);
    chk("R9 slowed expiry", fault, 1);

    // R8 fast timer spans fast and cv; R2 direct to fast
    do_reset();
    scale = 2'd0;
    set_flags(11'b11110000100); cyc(2);
    chk("R2 direct fast", phase, 3);
    pulse(5);
    set_flags(11'b11111000100); cyc(1);
    chk("R8 cv entered", phase, 4);
    pulse(P_FAST - 6); cyc(1);
    chk("R8 cv before expiry", phase, 4);
    pulse(1); cyc(1);
    chk("R8 fast expiry", fault, 1);

    // R11/R10 over-voltage pause
    do_reset();
    set_flags(11'b11100000100); cyc(2);
    set_flags(11'b11100000101); cyc(1);
    chk("R11 ovp isel", isel, 0);
    chk("R10 ovp stat", stat_on, 0);
    pulse(P_PRE + 2); cyc(1);
    chk("R11 ovp timer frozen", phase, 2);
    set_flags(11'b11110000101); cyc(1);
    chk("R11 ovp phase held", phase, 2);
    set_flags(11'b11110000100); cyc(1);
    chk("R11 resume fast", phase, 3);
    chk("R11 resume isel", isel, 2);
    chk("R10 resume stat", stat_on, 1);

    // R12/R11 thermistor
    do_reset();
    set_flags(11'b11100001100); cyc(2);
    chk("R12 ts enable", ts_en, 1);
    set_flags(11'b11100001000); cyc(1);
    chk("R11 temp pause isel", isel, 0);
    chk("R11 temp pause phase", phase, 2);
    set_flags(11'b11100000000); cyc(1);
    chk("R12 no thermistor", ts_en, 0);
    chk("R12 no thermistor isel", isel, 1);

    // R6 battery gone at recheck
    do_reset();
    set_flags(11'b11110000100); cyc(2);
    set_flags(11'b11111000100); cyc(1);
    set_flags(11'b11111010100); cyc(1);
    chk("R5 done", phase, 5);
    set_flags(11'b11010100100); cyc(2);
    chk("R6 absent fault", phase, 8);
    set_flags(11'b01010100100); cyc(1);
    chk("R13 disable clears", fault, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule